// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects interrupt requests from five sources on behalf of a small processor core. The sources are one external pin and four internal events: timer 0 overflow, timer 1 overflow, converter done and time-base overflow. Each source has a request flag and an enable bit. A single global enable gates all of them. The external pin goes through a synchronizer and an edge detector, and a two-bit code selects which edges count.

The core supplies an instruction-cycle strobe (`tick`). On a strobe the block arbitrates the pending, enabled requests by fixed priority. It clears the winner's flag and the global enable, reports that service has started, and issues a take pulse with the vector address a fixed number of strobes later. The delay is longer when the service was woken from sleep. While the core sleeps, any enabled pending request raises a wake output. A full return-address stack holds off service. A return-from-interrupt pulse re-opens the global enable. Software reaches the flags, enables, global enable and edge code through single-cycle write strobes.

Top module: `irq_ctrl`

## Requirements
- R1: When several eligible requests wait at the same strobe, the lowest-numbered source wins. The source numbers are 0 external, 1 timer 0, 2 timer 1, 3 converter done and 4 time base.
- R2: `irq_vec` carries 0x04 + 4 × source number, so 0x04, 0x08, 0x0C, 0x10 or 0x14. It is valid in the cycle `irq_take` is high.
- R3: `sel_wdata` chooses the external edge as follows: 2'b00 turns the external source off, 2'b01 selects rising, 2'b10 selects falling and 2'b11 selects both.
- R4: A source is serviced only when its flag, its enable bit and the global enable are all 1.
- R5: Starting a service clears that source's flag and the global enable in the same clock edge.
- R6: While `stk_full` is high no service starts, and the request flag stays set.
- R7: Arbitration happens only on clock edges where `tick` is high. A request that arrives between strobes is acted on at the next strobe.
- R8: `irq_take` pulses one cycle after the 2nd strobe following the service-start strobe. If the wake output was raised before that start, it pulses after the 3rd strobe.
- R9: A `flag_set` bit sets a flag just as a hardware event does, and a `flag_clr` bit clears it. If both arrive in one cycle, the set wins.
- R10: The external pin passes through two flip-flops. A qualifying transition shows in `flags_o[0]` after the 3rd clock edge. No transition is detected while `ext_is_input` is 0.
- R11: `reti` sets the global enable, and pending flags compete again at the next strobe.
- R12: While `sleep` is high, `wake` is 1 whenever some flag and its enable bit are both 1, whatever the global enable.
- R13: After reset all flags, enables and the global enable are 0, the edge code is 00, and `irq_take`, `svc_started` and `wake` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Instruction-cycle strobe, the sampling point |
| sleep | input | 1 | Core is in sleep mode |
| stk_full | input | 1 | Return-address stack is full |
| reti | input | 1 | Return-from-interrupt pulse |
| ext_pin | input | 1 | Asynchronous external request pin |
| ext_is_input | input | 1 | Pin is configured as an input |
| evt_in | input | 4 | Internal event pulses, sources 1..4 |
| sel_wr | input | 1 | Write strobe for the edge code |
| sel_wdata | input | 2 | Edge code to write |
| en_wr | input | 1 | Write strobe for the enable bits |
| en_wdata | input | 5 | Enable bits to write |
| flag_set | input | 5 | Software set of request flags |
| flag_clr | input | 5 | Software clear of request flags |
| gie_set | input | 1 | Software set of the global enable |
| gie_clr | input | 1 | Software clear of the global enable |
| wake | output | 1 | Wake request while sleeping |
| irq_take | output | 1 | One-cycle vector jump pulse |
| irq_vec | output | 8 | Vector address |
| svc_started | output | 1 | One-cycle pulse after a service starts |
| gie_o | output | 1 | Global enable state |
| flags_o | output | 5 | Request flag state |

## Verification
The arbiter is driven in four ways. In the first, all five flags are set at once, which separates the priority order and the vector table, since each return exposes the next winner. In the second, requests are raised with one gate missing at a time (enable, global enable, stack room), so a missing term is told apart from a wrong one. In the third, requests come from sleep, which separates the 2- and 3-strobe latencies. In the fourth, the external pin is toggled under every edge code and with the pin not configured as an input, with the flag sampled edge by edge to pin down the synchronizer depth.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int NSRC     = 5;
    localparam int SRC_W    = $clog2(NSRC);
    localparam int VEC_W    = 8;
    localparam int VEC_STEP = 4;
    localparam logic [VEC_W-1:0] VEC_BASE = 8'h04;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_e;

    typedef logic [NSRC-1:0] src_vec_t;

    typedef struct packed {
        logic             valid;
        logic [SRC_W-1:0] idx;
    } grant_t;

    // lowest index wins: scan from the top so the last hit is the lowest
    function automatic grant_t pick_winner(src_vec_t ready);
        grant_t g;
        g.valid = 1'b0;
        g.idx   = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (ready[i]) begin
                g.valid = 1'b1;
                g.idx   = SRC_W'(i);
            end
        end
        return g;
    endfunction

    function automatic logic [VEC_W-1:0] vec_of(logic [SRC_W-1:0] idx);
        return VEC_BASE + VEC_W'(idx) * VEC_W'(VEC_STEP);
    endfunction

endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect
    import irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pin,
    input  logic       pin_is_input,
    input  logic       sel_wr,
    input  logic [1:0] sel_wdata,
    output logic       evt
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    edge_mode_e             mode_q;
    logic                   cur, rise, fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
            mode_q <= EDGE_OFF;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
            prev_q <= sync_q[SYNC_STAGES-1];
            if (sel_wr)
                mode_q <= edge_mode_e'(sel_wdata);
        end
    end

    assign cur  = sync_q[SYNC_STAGES-1];
    assign rise = cur & ~prev_q;
    assign fall = ~cur & prev_q;

    always_comb begin
        unique case (mode_q)
            EDGE_RISE: evt = rise;
            EDGE_FALL: evt = fall;
            EDGE_BOTH: evt = rise | fall;
            default:   evt = 1'b0;
        endcase
        if (!pin_is_input)
            evt = 1'b0;
    end

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t hw_evt,
    input  src_vec_t sw_set,
    input  src_vec_t sw_clr,
    input  logic     en_wr,
    input  src_vec_t en_wdata,
    input  logic     gie_set,
    input  logic     gie_clr,
    input  logic     reti,
    input  logic     svc_take,
    input  src_vec_t svc_clr,
    output src_vec_t flags,
    output src_vec_t enables,
    output logic     gie
);
    src_vec_t flags_n;

    // clears first, then any set (software or hardware) wins
    assign flags_n = (flags & ~sw_clr & ~svc_clr) | sw_set | hw_evt;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags   <= '0;
            enables <= '0;
            gie     <= 1'b0;
        end else begin
            flags <= flags_n;
            if (en_wr)
                enables <= en_wdata;
            if (svc_take)
                gie <= 1'b0;
            else if (gie_set || reti)
                gie <= 1'b1;
            else if (gie_clr)
                gie <= 1'b0;
        end
    end

    // R5: a serviced flag is gone next cycle unless a new set hit it
    p_svc_flag_r5: assert property (@(posedge clk) disable iff (rst)
        (svc_take && ((svc_clr & (sw_set | hw_evt)) == '0))
        |=> ((flags & $past(svc_clr)) == '0));

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int LAT_RUN  = 2,
    parameter int LAT_WAKE = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             sleep,
    input  logic             stk_full,
    input  logic             gie,
    input  src_vec_t         flags,
    input  src_vec_t         enables,
    output logic             capture,
    output src_vec_t         svc_clr,
    output logic             wake,
    output logic             busy,
    output logic             started,
    output logic             take,
    output logic [VEC_W-1:0] vec
);
    localparam int LAT_MAX = (LAT_WAKE > LAT_RUN) ? LAT_WAKE : LAT_RUN;
    localparam int CNT_W   = $clog2(LAT_MAX + 1);

    src_vec_t         ready;
    grant_t           g;
    logic             woke_q;
    logic [CNT_W-1:0] cnt_q;
    logic [SRC_W-1:0] idx_q;

    assign ready   = flags & enables;
    assign g       = pick_winner(ready);
    assign wake    = sleep & (|ready);
    assign capture = tick & gie & g.valid & ~stk_full & ~busy;

    always_comb begin
        svc_clr = '0;
        if (capture)
            svc_clr[g.idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            woke_q  <= 1'b0;
            busy    <= 1'b0;
            cnt_q   <= '0;
            idx_q   <= '0;
            started <= 1'b0;
            take    <= 1'b0;
            vec     <= '0;
        end else begin
            take    <= 1'b0;
            started <= capture;
            woke_q  <= capture ? 1'b0 : (woke_q | wake);
            if (capture) begin
                busy  <= 1'b1;
                idx_q <= g.idx;
                cnt_q <= (sleep || woke_q) ? CNT_W'(LAT_WAKE) : CNT_W'(LAT_RUN);
            end else if (busy && tick) begin
                if (cnt_q == CNT_W'(1)) begin
                    busy <= 1'b0;
                    take <= 1'b1;
                    vec  <= vec_of(idx_q);
                end else begin
                    cnt_q <= cnt_q - CNT_W'(1);
                end
            end
        end
    end

    // R2: every issued vector lies in the table
    p_take_vec_r2: assert property (@(posedge clk) disable iff (rst)
        take |-> (vec[1:0] == 2'b00 && vec >= 8'h04 && vec <= 8'h14));

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int LAT_RUN     = 2,
    parameter int LAT_WAKE    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             sleep,
    input  logic             stk_full,
    input  logic             reti,
    input  logic             ext_pin,
    input  logic             ext_is_input,
    input  logic [NSRC-2:0]  evt_in,
    input  logic             sel_wr,
    input  logic [1:0]       sel_wdata,
    input  logic             en_wr,
    input  logic [NSRC-1:0]  en_wdata,
    input  logic [NSRC-1:0]  flag_set,
    input  logic [NSRC-1:0]  flag_clr,
    input  logic             gie_set,
    input  logic             gie_clr,
    output logic             wake,
    output logic             irq_take,
    output logic [VEC_W-1:0] irq_vec,
    output logic             svc_started,
    output logic             gie_o,
    output logic [NSRC-1:0]  flags_o
);
    logic     ext_evt;
    src_vec_t flags, enables, svc_clr;
    logic     gie, capture, busy;

    irq_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk          (clk),
        .rst          (rst),
        .pin          (ext_pin),
        .pin_is_input (ext_is_input),
        .sel_wr       (sel_wr),
        .sel_wdata    (sel_wdata),
        .evt          (ext_evt)
    );

    irq_flag_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .hw_evt   ({evt_in, ext_evt}),
        .sw_set   (flag_set),
        .sw_clr   (flag_clr),
        .en_wr    (en_wr),
        .en_wdata (en_wdata),
        .gie_set  (gie_set),
        .gie_clr  (gie_clr),
        .reti     (reti),
        .svc_take (capture),
        .svc_clr  (svc_clr),
        .flags    (flags),
        .enables  (enables),
        .gie      (gie)
    );

    irq_arbiter #(.LAT_RUN(LAT_RUN), .LAT_WAKE(LAT_WAKE)) u_arb (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .sleep    (sleep),
        .stk_full (stk_full),
        .gie      (gie),
        .flags    (flags),
        .enables  (enables),
        .capture  (capture),
        .svc_clr  (svc_clr),
        .wake     (wake),
        .busy     (busy),
        .started  (svc_started),
        .take     (irq_take),
        .vec      (irq_vec)
    );

    assign gie_o   = gie;
    assign flags_o = flags;

    // R4: a service only begins from an open global enable
    p_no_nest_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(gie));

    // R5: global enable is closed once a service is under way
    p_gie_drop_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !gie);

    // R6: no service begins from a full stack
    p_stk_hold_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !$past(stk_full));

    // R7: service start follows a strobe edge
    p_on_strobe_r7: assert property (@(posedge clk) disable iff (rst)
        svc_started |-> $past(tick));

endmodule

// File: tb/irq_ctrl_test.sv
module irq_ctrl_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       sleep, stk_full, reti, ext_pin, ext_is_input;
    logic [3:0] evt_in;
    logic       sel_wr, en_wr, gie_set, gie_clr;
    logic [1:0] sel_wdata;
    logic [4:0] en_wdata, flag_set, flag_clr;
    logic       wake, irq_take, svc_started, gie_o;
    logic [7:0] irq_vec;
    logic [4:0] flags_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    irq_ctrl uut (
        .clk(clk), .rst(rst), .tick(tick), .sleep(sleep), .stk_full(stk_full),
        .reti(reti), .ext_pin(ext_pin), .ext_is_input(ext_is_input),
        .evt_in(evt_in), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
        .en_wr(en_wr), .en_wdata(en_wdata), .flag_set(flag_set),
        .flag_clr(flag_clr), .gie_set(gie_set), .gie_clr(gie_clr),
        .wake(wake), .irq_take(irq_take), .irq_vec(irq_vec),
        .svc_started(svc_started), .gie_o(gie_o), .flags_o(flags_o)
    );

    // strobe: one cycle in four, changed just after a rising edge
    initial begin
        forever begin
            repeat (3) @(posedge clk);
            #1 tick = 1'b1;
            @(posedge clk);
            #1 tick = 1'b0;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; sleep = 0; stk_full = 0; reti = 0; ext_pin = 0; ext_is_input = 1;
        evt_in = '0; sel_wr = 0; sel_wdata = '0; en_wr = 0; en_wdata = '0;
        flag_set = '0; flag_clr = '0; gie_set = 0; gie_clr = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic write_en(input logic [4:0] v);
        en_wr = 1; en_wdata = v; @(negedge clk); en_wr = 0;
    endtask

    task automatic write_sel(input logic [1:0] v);
        sel_wr = 1; sel_wdata = v; @(negedge clk); sel_wr = 0;
    endtask

    task automatic pulse_gie();
        gie_set = 1; @(negedge clk); gie_set = 0;
    endtask

    task automatic pulse_reti();
        reti = 1; @(negedge clk); reti = 0;
    endtask

    task automatic sw_set(input logic [4:0] v);
        flag_set = v; @(negedge clk); flag_set = '0;
    endtask

    task automatic sw_clr(input logic [4:0] v);
        flag_clr = v; @(negedge clk); flag_clr = '0;
    endtask

    // waits for service start, then counts strobes until the vector pulse
    task automatic wait_take(input string req, input int exp_ticks, input logic [7:0] exp_vec);
        int guard = 0;
        int n = 0;
        while (!svc_started && guard < 200) begin @(negedge clk); guard++; end
        check({req, " service started"}, 32'(svc_started), 32'd1);
        while (!irq_take && guard < 400) begin
            if (tick) n++;
            @(negedge clk);
            guard++;
        end
        check("R8 strobes to take", 32'(n), 32'(exp_ticks));
        check({req, " vector"}, 32'(irq_vec), 32'(exp_vec));
    endtask

    task automatic quiet(input string req, input int cycles);
        int seen = 0;
        for (int i = 0; i < cycles; i++) begin
            if (svc_started || irq_take) seen = 1;
            @(negedge clk);
        end
        check(req, 32'(seen), 32'd0);
    endtask

    task automatic t_reset();
        do_reset();
        check("R13 flags", 32'(flags_o), 0);
        check("R13 gie", 32'(gie_o), 0);
        check("R13 take", 32'(irq_take), 0);
        check("R13 started", 32'(svc_started), 0);
        check("R13 wake", 32'(wake), 0);
    endtask

    task automatic t_priority_chain();
        do_reset();
        write_en(5'h1F);
        sw_set(5'h1F);                       // R9: software raise of all five
        check("R9 software set", 32'(flags_o), 32'h1F);
        pulse_gie();
        for (int i = 0; i < 5; i++) begin
            wait_take("R1", 2, 8'(4 + 4 * i));   // R2 table, R8 awake latency
            check("R5 flag cleared", 32'(flags_o[i]), 0);
            check("R5 gie closed", 32'(gie_o), 0);
            pulse_reti();
            check("R11 reti reopens", 32'(gie_o), 1);
        end
        check("R5 all serviced", 32'(flags_o), 0);
    endtask

    task automatic t_pair();
        do_reset();
        write_en(5'h1F);
        evt_in = 4'b1010;                    // timer 1 and time base together
        @(negedge clk); evt_in = '0;
        pulse_gie();
        wait_take("R1 pair", 2, 8'h0C);
    endtask

    task automatic t_gating();
        do_reset();
        write_en(5'b11101);
        sw_set(5'b00010);
        pulse_gie();
        quiet("R4 enable bit off", 24);
        check("R4 flag held", 32'(flags_o[1]), 1);
        gie_clr = 1; @(negedge clk); gie_clr = 0;
        write_en(5'h1F);
        quiet("R4 global enable off", 24);
        pulse_gie();
        wait_take("R4", 2, 8'h08);
    endtask

    task automatic t_stack();
        do_reset();
        write_en(5'h1F);
        stk_full = 1;
        sw_set(5'b00100);
        pulse_gie();
        quiet("R6 stack full", 24);
        check("R6 flag pending", 32'(flags_o[2]), 1);
        stk_full = 0;
        wait_take("R6", 2, 8'h0C);
    endtask

    task automatic t_strobe();
        int n = 0;
        int guard = 0;
        do_reset();
        write_en(5'h1F);
        pulse_gie();
        while (!tick) @(negedge clk);
        sw_set(5'b01000);                    // flag lands on a strobe edge
        while (!svc_started && guard < 100) begin
            if (tick) n++;
            @(negedge clk);
            guard++;
        end
        check("R7 waits for next strobe", 32'(n), 32'd1);
        wait_take("R7", 2, 8'h10);
    endtask

    task automatic t_sw_conflict();
        do_reset();
        flag_set = 5'b00100; flag_clr = 5'b00100;
        @(negedge clk);
        flag_set = '0; flag_clr = '0;
        check("R9 set beats clear", 32'(flags_o), 32'h04);
        sw_clr(5'b00100);
        check("R9 software clear", 32'(flags_o), 0);
    endtask

    task automatic pin_to(input logic v, input logic exp_flag, input string req);
        ext_pin = v;
        @(negedge clk);
        @(negedge clk);
        check({req, " not yet"}, 32'(flags_o[0]), 0);
        @(negedge clk);
        check(req, 32'(flags_o[0]), 32'(exp_flag));
        repeat (2) @(negedge clk);
        sw_clr(5'b00001);
    endtask

    task automatic t_edges();
        do_reset();
        write_en(5'h1F);
        pin_to(1, 0, "R3 off code 00 rise");
        pin_to(0, 0, "R3 off code 00 fall");
        write_sel(2'b01);
        pin_to(1, 1, "R10 rise code 01");
        pin_to(0, 0, "R3 rise code 01 ignores fall");
        write_sel(2'b10);
        pin_to(1, 0, "R3 fall code 10 ignores rise");
        pin_to(0, 1, "R3 fall code 10");
        write_sel(2'b11);
        pin_to(1, 1, "R3 both code 11 rise");
        pin_to(0, 1, "R3 both code 11 fall");
        ext_is_input = 0;
        pin_to(1, 0, "R10 not input");
        ext_is_input = 1;
        ext_pin = 0;
        repeat (4) @(negedge clk);
        sw_clr(5'b00001);
        write_sel(2'b01);
        pulse_gie();
        ext_pin = 1;
        wait_take("R10 pin service", 2, 8'h04);
    endtask

    task automatic t_sleep();
        do_reset();
        write_en(5'b01000);
        sleep = 1;
        check("R12 no wake idle", 32'(wake), 0);
        evt_in = 4'b0100;                    // converter done
        @(negedge clk); evt_in = '0;
        check("R12 wake without gie", 32'(wake), 1);
        quiet("R4 no service asleep gie off", 16);
        pulse_gie();
        wait_take("R12", 3, 8'h10);
        sleep = 0;
        check("R12 wake cleared", 32'(wake), 0);
    endtask

    initial begin
        #500000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_priority_chain();
        t_pair();
        t_gating();
        t_stack();
        t_strobe();
        t_sw_conflict();
        t_edges();
        t_sleep();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule